// File: doc/BRIEF.md
# SATA Bridge Port Bring-Up Sequencer

This block brings up one of two parallel-ATA-to-serial-ATA bridge ports in hardware and decides whether the port is usable. It holds a 3-bit routing mode, which chooses how the two ATA controllers are paired with the two bridge ports, and a global bridge-enable flag. From these two values it derives, for each ATA controller, whether a serial bridge sits behind it. The routing mode is also presented in a 32-bit miscellaneous control field at bits 26:24, where the pad multiplexer decodes it.

A start request names a port. The sequencer turns that port's clock on and waits a settle time. It then issues a one-cycle write of the port's control word and waits a second settle time. After that it samples the port's PHY-ready status bit once per poll period. It stops at the first sample that shows the link ready, or at the first sample taken once the poll limit has passed since the control write. One done pulse reports pass or fail and the port number. A port that fails has its clock turned off again. A port that passes stays clocked until a stop request names it. Every delay is a parameter counted in clock ticks.

Top module: `sata_bringup_seq`

## Requirements
- R1: After reset both port clock enables are 0, busy is 0, bridge enable is 0, both linked flags are 0, and the misc control field is 0, which means routing mode 0.
- R2: A configuration write with a mode code of 0 to 3 stores both the mode and the bridge enable. The mode then appears at misc_ctrl_o[26:24] and every other bit of that field is 0. A write with a code of 4 to 7 is rejected whole: neither the mode nor the bridge enable changes.
- R3: ata_linked_o[0] is 1 only when bridge enable is 1 and the mode is not 2. ata_linked_o[1] is 1 only when bridge enable is 1 and the mode is not 3.
- R4: A start request that is sampled while the sequencer is idle sets that port's clock enable and busy in the next cycle. Call the sampling edge edge 0 and the cycle after it cycle 1.
- R5: ctrl_we_o is high for exactly one cycle, cycle CLK_SETTLE+1. In that cycle ctrl_word_o has bit 4 (hotplug detect) and bit 0 (bridge enable) set, and every bit from 15 down to 5 and bits 3:2 clear.
- R6: Control-word bit 1 (slave enable) is set for port 0 only in mode 2, and for port 1 only in mode 3.
- R7: Sample k (k = 1, 2, ...) reads the active port's phy_rdy_i bit at the end of cycle CLK_SETTLE+1+CTRL_SETTLE+k·POLL_PERIOD. The done pulse lasts one cycle, in the cycle after the deciding sample, with busy low.
- R8: The result is pass at the first sample that sees ready. It is fail at the first sample with CTRL_SETTLE+k·POLL_PERIOD ≥ POLL_LIMIT that does not see ready.
- R9: On fail the port's clock enable is 0 from the done cycle onward. On pass it stays 1.
- R10: A stop request clears the named port's clock enable in the next cycle. A stop request for the port of a running sequence is ignored.
- R11: A start request that arrives while busy is ignored. The other port's clock stays off, and only one done pulse occurs.
- R12: The ready input of the port that is not being sequenced has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Requested routing mode |
| cfg_bridge_en | input | 1 | Requested global bridge enable |
| start_req | input | 1 | Start bring-up request |
| start_port | input | 1 | Port to bring up |
| stop_req | input | 1 | Stop request |
| stop_port | input | 1 | Port to stop |
| phy_rdy_i | input | 2 | PHY-ready status bit of each port |
| port_clk_en_o | output | 2 | Per-port clock enable |
| ctrl_we_o | output | 1 | Control-word write strobe |
| ctrl_port_o | output | 1 | Port addressed by the current or last sequence |
| ctrl_word_o | output | 16 | Control word for the port |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result that goes with done |
| done_port_o | output | 1 | Port that goes with done |
| ata_linked_o | output | 2 | Per-ATA-controller bridge-connected flag |
| bridge_en_o | output | 1 | Stored global bridge enable |
| misc_ctrl_o | output | 32 | Misc control field, routing mode at bits 26:24 |

## Verification
If the sequencer state or its counters go wrong, the control write or the done pulse moves by a whole tick count. The bench catches that in the first sequence, because it records the exact cycle of each event and compares it with the schedule it computes itself. If the mode register or the slave-bit derivation is wrong, the linked flags or control bit 1 go wrong in the same cycle as the configuration write or the control write. A wrong clock-gate decision shows as a clock enable that is off while busy, or still on in the done cycle of a failed port. A sweep over both ports, all four valid modes and ready timings placed on either side of the first and last samples brings out each of these at once.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NPORT    = 2;
  localparam int MODE_W   = 3;
  localparam int CTRL_W   = 16;
  localparam int MISC_W   = 32;
  localparam int MODE_LSB = 24;

  localparam int CB_EN      = 0;
  localparam int CB_SLAVE   = 1;
  localparam int CB_HOTPLUG = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLKWAIT,
    ST_WRITE,
    ST_SETTLE,
    ST_POLL
  } seq_st_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return m < 3'd4;
  endfunction

  function automatic logic slave_for(input logic port, input logic [MODE_W-1:0] m);
    return (!port && m == 3'd2) || (port && m == 3'd3);
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_word(input logic port, input logic [MODE_W-1:0] m);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[CB_EN]      = 1'b1;
    w[CB_HOTPLUG] = 1'b1;
    w[CB_SLAVE]   = slave_for(port, m);
    return w;
  endfunction

  function automatic logic [NPORT-1:0] linked(input logic en, input logic [MODE_W-1:0] m);
    logic [NPORT-1:0] l;
    l[0] = en && (m != 3'd2);
    l[1] = en && (m != 3'd3);
    return l;
  endfunction
endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_bridge_en,
  output logic [MODE_W-1:0] mode_o,
  output logic              bridge_en_o,
  output logic [NPORT-1:0]  linked_o,
  output logic [MISC_W-1:0] misc_o,
  output logic              reject_o
);
  logic [MODE_W-1:0] mode_q;
  logic              en_q;

  assign reject_o = cfg_we && !mode_ok(cfg_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we && mode_ok(cfg_mode)) begin
      mode_q <= cfg_mode;
      en_q   <= cfg_bridge_en;
    end
  end

  always_comb begin
    misc_o = '0;
    misc_o[MODE_LSB +: MODE_W] = mode_q;
  end

  assign mode_o      = mode_q;
  assign bridge_en_o = en_q;
  assign linked_o    = linked(en_q, mode_q);
endmodule

// File: rtl/sbs_port_clk.sv
module sbs_port_clk #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] on_i,
  input  logic [NP-1:0] off_i,
  output logic [NP-1:0] en_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic en_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (on_i[p])  en_q <= 1'b1;
      else if (off_i[p]) en_q <= 1'b0;
    end
    assign en_o[p] = en_q;
  end
endmodule

// File: rtl/sbs_seq.sv
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int CLK_SETTLE  = 500000,
  parameter int CTRL_SETTLE = 500000,
  parameter int POLL_PERIOD = 5000000,
  parameter int POLL_LIMIT  = 50000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              start_port,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NPORT-1:0]  phy_rdy_i,
  output logic              busy_o,
  output logic              port_o,
  output logic              ctrl_we_o,
  output logic [CTRL_W-1:0] ctrl_word_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [NPORT-1:0]  clk_on_o,
  output logic [NPORT-1:0]  clk_off_o,
  output logic              start_acc_o,
  output logic              sample_o
);
  localparam int MAXT  = CLK_SETTLE + CTRL_SETTLE + POLL_PERIOD + POLL_LIMIT + 2;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] S_T = CNT_W'(CLK_SETTLE);
  localparam logic [CNT_W-1:0] C_T = CNT_W'(CTRL_SETTLE);
  localparam logic [CNT_W-1:0] P_T = CNT_W'(POLL_PERIOD);
  localparam logic [CNT_W-1:0] L_T = CNT_W'(POLL_LIMIT);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  el_q;
  logic              port_q;
  logic              done_q;
  logic              pass_q;
  logic [CTRL_W-1:0] word_q;
  logic              rdy;
  logic              limit_hit;
  logic              fail_evt;

  assign rdy         = phy_rdy_i[port_q];
  assign start_acc_o = (st_q == ST_IDLE) && start_req;
  assign sample_o    = (st_q == ST_POLL) && (cnt_q == P_T);
  assign limit_hit   = (el_q >= L_T);
  assign fail_evt    = sample_o && !rdy && limit_hit;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v >= L_T) ? v : v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      el_q   <= '0;
      port_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_req) begin
            port_q <= start_port;
            cnt_q  <= ONE;
            st_q   <= ST_CLKWAIT;
          end
        end
        ST_CLKWAIT: begin
          if (cnt_q == S_T) begin
            word_q <= ctrl_word(port_q, mode_i);
            st_q   <= ST_WRITE;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_WRITE: begin
          cnt_q <= ONE;
          el_q  <= ONE;
          st_q  <= ST_SETTLE;
        end
        ST_SETTLE: begin
          el_q <= sat_inc(el_q);
          if (cnt_q == C_T) begin
            cnt_q <= ONE;
            st_q  <= ST_POLL;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_POLL: begin
          el_q <= sat_inc(el_q);
          if (cnt_q == P_T) begin
            if (rdy) begin
              done_q <= 1'b1;
              pass_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (limit_hit) begin
              done_q <= 1'b1;
              pass_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              cnt_q <= ONE;
            end
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    assign clk_on_o[p]  = start_acc_o && (start_port == 1'(p));
    assign clk_off_o[p] = fail_evt && (port_q == 1'(p));
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign port_o      = port_q;
  assign ctrl_we_o   = (st_q == ST_WRITE);
  assign ctrl_word_o = word_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
endmodule

// File: rtl/sata_bringup_seq.sv
module sata_bringup_seq
  import sbs_pkg::*;
#(
  parameter int CLK_SETTLE  = 500000,
  parameter int CTRL_SETTLE = 500000,
  parameter int POLL_PERIOD = 5000000,
  parameter int POLL_LIMIT  = 50000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_mode,
  input  logic        cfg_bridge_en,
  input  logic        start_req,
  input  logic        start_port,
  input  logic        stop_req,
  input  logic        stop_port,
  input  logic [1:0]  phy_rdy_i,
  output logic [1:0]  port_clk_en_o,
  output logic        ctrl_we_o,
  output logic        ctrl_port_o,
  output logic [15:0] ctrl_word_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        pass_o,
  output logic        done_port_o,
  output logic [1:0]  ata_linked_o,
  output logic        bridge_en_o,
  output logic [31:0] misc_ctrl_o
);
  logic [MODE_W-1:0] mode_w;
  logic              cfg_reject_w;
  logic [NPORT-1:0]  clk_on_w;
  logic [NPORT-1:0]  fail_off_w;
  logic [NPORT-1:0]  stop_off_w;
  logic [NPORT-1:0]  clk_off_w;
  logic              start_acc_w;
  logic              sample_w;
  logic              seq_port_w;
  logic              busy_w;

  sbs_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_mode     (cfg_mode),
    .cfg_bridge_en(cfg_bridge_en),
    .mode_o       (mode_w),
    .bridge_en_o  (bridge_en_o),
    .linked_o     (ata_linked_o),
    .misc_o       (misc_ctrl_o),
    .reject_o     (cfg_reject_w)
  );

  sbs_seq #(
    .CLK_SETTLE (CLK_SETTLE),
    .CTRL_SETTLE(CTRL_SETTLE),
    .POLL_PERIOD(POLL_PERIOD),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .start_port (start_port),
    .mode_i     (mode_w),
    .phy_rdy_i  (phy_rdy_i),
    .busy_o     (busy_w),
    .port_o     (seq_port_w),
    .ctrl_we_o  (ctrl_we_o),
    .ctrl_word_o(ctrl_word_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .clk_on_o   (clk_on_w),
    .clk_off_o  (fail_off_w),
    .start_acc_o(start_acc_w),
    .sample_o   (sample_w)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_stop
    assign stop_off_w[p] = stop_req && (stop_port == 1'(p))
                           && !(busy_w && seq_port_w == 1'(p));
  end
  assign clk_off_w = fail_off_w | stop_off_w;

  sbs_port_clk #(.NP(NPORT)) u_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .on_i (clk_on_w),
    .off_i(clk_off_w),
    .en_o (port_clk_en_o)
  );

  assign busy_o      = busy_w;
  assign ctrl_port_o = seq_port_w;
  assign done_port_o = seq_port_w;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_acc,
  input logic        sample,
  input logic        cfg_reject,
  input logic [1:0]  clk_en,
  input logic        ctrl_we,
  input logic [15:0] ctrl_word,
  input logic        busy,
  input logic        port,
  input logic        done,
  input logic        pass,
  input logic [1:0]  linked,
  input logic        bridge_en,
  input logic [31:0] misc
);
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);

  // R4
  busy_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> clk_en[port]);

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !ctrl_we);

  // R5
  word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |-> (ctrl_word[4] && ctrl_word[0] && ctrl_word[15:5] == 11'd0 && ctrl_word[3:2] == 2'd0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sample));

  // R9
  fail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> !clk_en[port]);

  // R2
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc[26:24] < 3'd4);

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> ($stable(misc) && $stable(bridge_en)));

  // R3
  linked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |-> linked == 2'b00);
endmodule

bind sata_bringup_seq sbs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_acc (start_acc_w),
  .sample    (sample_w),
  .cfg_reject(cfg_reject_w),
  .clk_en    (port_clk_en_o),
  .ctrl_we   (ctrl_we_o),
  .ctrl_word (ctrl_word_o),
  .busy      (busy_o),
  .port      (ctrl_port_o),
  .done      (done_o),
  .pass      (pass_o),
  .linked    (ata_linked_o),
  .bridge_en (bridge_en_o),
  .misc      (misc_ctrl_o)
);

// File: tb/sata_bringup_seq_tb.sv
`timescale 1ns/1ps
module sata_bringup_seq_tb;
  localparam int S = 4;
  localparam int C = 3;
  localparam int P = 5;
  localparam int L = 20;
  localparam int NEVER = 999;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic        cfg_bridge_en = 1'b0;
  logic        start_req = 1'b0;
  logic        start_port = 1'b0;
  logic        stop_req = 1'b0;
  logic        stop_port = 1'b0;
  logic [1:0]  phy_rdy_i = '0;
  logic [1:0]  port_clk_en_o;
  logic        ctrl_we_o;
  logic        ctrl_port_o;
  logic [15:0] ctrl_word_o;
  logic        busy_o;
  logic        done_o;
  logic        pass_o;
  logic        done_port_o;
  logic [1:0]  ata_linked_o;
  logic        bridge_en_o;
  logic [31:0] misc_ctrl_o;

  int checks = 0;
  int failures = 0;
  int exp_mode = 0;
  int exp_en = 0;

  always #10 clk = ~clk;

  sata_bringup_seq #(
    .CLK_SETTLE(S), .CTRL_SETTLE(C), .POLL_PERIOD(P), .POLL_LIMIT(L)
  ) u_dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int m, input int en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 3'(m); cfg_bridge_en = 1'(en);
    @(negedge clk);
    cfg_we = 1'b0;
    if (m < 4) begin exp_mode = m; exp_en = en; end
  endtask

  task automatic stop(input int p);
    @(negedge clk);
    stop_req = 1'b1; stop_port = 1'(p);
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  // runs one bring-up; R is the first cycle with ready; sinj/tinj inject a start
  // for the other port or a stop for the active port in that cycle
  task automatic run_seq(input int p, input int R, input int sinj, input int tinj);
    int we_cyc = -1; int done_cyc = -1; int clk_bad = 0; int ndone = 0;
    logic [15:0] wd = '0; logic dpass = 1'b0; logic dport = 1'b0; logic clk_at_done = 1'b0;
    int exp_done = -1; bit exp_pass = 0; int exp_slave;
    logic [15:0] exp_word;
    for (int k = 1; k < 100; k++) begin
      int s = S + 1 + C + k * P;
      if (s >= R) begin exp_pass = 1; exp_done = s + 1; break; end
      if (C + k * P >= L) begin exp_pass = 0; exp_done = s + 1; break; end
    end
    exp_slave = ((p == 0 && exp_mode == 2) || (p == 1 && exp_mode == 3)) ? 1 : 0;
    exp_word = 16'h0011 | 16'(exp_slave << 1);
    @(negedge clk);
    start_req = 1'b1; start_port = 1'(p);
    @(posedge clk); #1;
    for (int c = 1; c <= 60; c++) begin
      phy_rdy_i[p]   = (c >= R);
      phy_rdy_i[1-p] = 1'b1;
      start_req  = (c == sinj);
      start_port = 1'(1 - p);
      stop_req   = (c == tinj);
      stop_port  = 1'(p);
      if (ctrl_we_o) begin
        if (we_cyc < 0) we_cyc = c; else we_cyc = 1000;
        wd = ctrl_word_o;
      end
      if (busy_o && !port_clk_en_o[p]) clk_bad++;
      if (port_clk_en_o[1-p]) clk_bad++;
      if (done_o) begin
        ndone++;
        if (done_cyc < 0) begin
          done_cyc = c; dpass = pass_o; dport = done_port_o; clk_at_done = port_clk_en_o[p];
        end
      end
      @(posedge clk); #1;
    end
    start_req = 1'b0; stop_req = 1'b0; phy_rdy_i = '0;
    check(we_cyc == S + 1, "R5 write cycle", we_cyc, S + 1);
    check(wd == exp_word, "R5/R6 control word", wd, exp_word);
    check(done_cyc == exp_done, "R7 done cycle", done_cyc, exp_done);
    check(dpass == exp_pass, "R8 pass result", dpass, exp_pass);
    check(dport == 1'(p), "R7 done port", dport, p);
    check(clk_at_done == exp_pass, "R9 clock at done", clk_at_done, exp_pass);
    check(port_clk_en_o[p] == exp_pass, "R9 clock after done", port_clk_en_o[p], exp_pass);
    check(clk_bad == 0, "R4/R10/R11 clock enables during run", clk_bad, 0);
    check(ndone == 1, "R11 single done", ndone, 1);
    stop(p);
    #1;
    check(port_clk_en_o[p] == 1'b0, "R10 stop clears clock", port_clk_en_o[p], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rlist[6];
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(port_clk_en_o == 2'b00, "R1 clocks off", port_clk_en_o, 0);
    check(busy_o == 1'b0, "R1 idle", busy_o, 0);
    check(bridge_en_o == 1'b0, "R1 bridge off", bridge_en_o, 0);
    check(ata_linked_o == 2'b00, "R1 linked", ata_linked_o, 0);
    check(misc_ctrl_o == 32'd0, "R1 misc", misc_ctrl_o, 0);

    // R2/R3 sweep over every code and enable
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 8; m++) begin
        int l0; int l1;
        cfg(m, en);
        #1;
        l0 = (exp_en == 1 && exp_mode != 2) ? 1 : 0;
        l1 = (exp_en == 1 && exp_mode != 3) ? 1 : 0;
        check(misc_ctrl_o == (32'(exp_mode) << 24), "R2 misc field", misc_ctrl_o, 32'(exp_mode) << 24);
        check(bridge_en_o == 1'(exp_en), "R2 bridge enable", bridge_en_o, exp_en);
        check(ata_linked_o == {1'(l1), 1'(l0)}, "R3 linked flags", ata_linked_o, (l1 << 1) | l0);
      end
    end

    // R4..R12 sweep: ports x modes x ready timing
    rlist[0] = 1;
    rlist[1] = S + 1 + C + P;
    rlist[2] = S + 2 + C + P;
    rlist[3] = S + 1 + C + 4 * P;
    rlist[4] = S + 2 + C + 4 * P;
    rlist[5] = NEVER;
    for (int m = 0; m < 4; m++) begin
      cfg(m, 1);
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 6; i++) begin
          int sinj = (i == 5) ? 6 : 0;
          int tinj = (i == 0) ? 10 : 0;
          run_seq(p, rlist[i], sinj, tinj);
        end
      end
    end

    // R10 stop of an idle-on port while the other port is sequenced
    cfg(0, 1);
    @(negedge clk); start_req = 1'b1; start_port = 1'b0;
    @(negedge clk); start_req = 1'b0;
    repeat (S + C + P + 4) @(negedge clk);
    @(negedge clk); phy_rdy_i = 2'b01;
    repeat (P + 2) @(negedge clk);
    phy_rdy_i = 2'b00;
    check(port_clk_en_o[0] == 1'b1, "R9 port0 kept on", port_clk_en_o[0], 1);
    @(negedge clk); start_req = 1'b1; start_port = 1'b1;
    @(negedge clk); start_req = 1'b0;
    stop(0);
    #1;
    check(port_clk_en_o[0] == 1'b0, "R10 stop other port while busy", port_clk_en_o[0], 0);
    check(port_clk_en_o[1] == 1'b1, "R10 active port untouched", port_clk_en_o[1], 1);
    repeat (60) @(negedge clk);
    check(port_clk_en_o[1] == 1'b0, "R9 port1 failed off", port_clk_en_o[1], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule